// File: doc/BRIEF.md
# Table-Driven Waveform Sequencer

The block builds a user-defined waveform by stepping through a stored table of 12-bit DAC sample codes. A simple write port loads the sample table, the number of table entries to play, a 16-bit tick reload value and a repeat/single-pass flag. The tick reload value sets the spacing between steps. A small reload gives closely spaced samples and so a steep output slope. A large reload spaces the samples out and gives a shallow slope.

Playback begins on either of two start requests: a local strobe or a command from the host side. Each step loads the next table entry into the DAC output register. In the same cycle the block pulses a report strobe, so that neighbouring logic can pass the value on to a host link or a display. In repeat mode the table address returns to entry 0 after the last entry, and the step spacing stays the same across that return. In single-pass mode the last sample is held for one step period. After that, the output drive enable drops to isolate the load, and the block waits until it is programmed again. An abort input stops playback at any time.

Top module: `wave_sequencer`

## Requirements
- R1: After reset, seq_state is 0 (idle), dac_code is 0, dac_oe is 0 and report_stb is 0. State codes are: 0 idle, 1 armed, 2 running, 3 done.
- R2: A cfg_we cycle writes according to cfg_sel. With cfg_sel 0 it writes cfg_data[11:0] into table entry cfg_addr. With cfg_sel 1 it writes the length, given as cfg_data[7:0] = length-1, so lengths run from 1 to 256. With cfg_sel 2 it writes the tick reload cfg_data[15:0]. With cfg_sel 3 it writes the mode, where cfg_data[0]=1 selects repeat. A mode write moves the block from idle, armed or done to armed. Any other write while done returns the block to idle.
- R3: A start_local or start_host pulse is acted on only in the armed state, where it moves the block to running. In idle and done, start pulses change nothing.
- R4: The first sample appears on dac_code one clock after the start is accepted. Each later sample follows reload+1 clocks after the previous one. Samples are played from table entry 0 upward.
- R5: report_stb is high for exactly one clock at each sample update, in the same cycle that dac_code takes the new value. It is low in every other cycle.
- R6: In repeat mode, entry 0 follows the last entry with the normal reload+1 spacing, for any length up to 256.
- R7: In single-pass mode, the last sample is held for reload+1 clocks. Then dac_oe goes low and seq_state becomes 3 with no further strobe. Start pulses are ignored until the next write.
- R8: Configuration writes made while running have no effect on the table, the length, the reload value or the mode.
- R9: abort returns the block to idle with dac_oe low on the next clock, from any state. abort takes priority over a start in the same cycle.
- R10: dac_oe rises with the first sample and stays high for the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 table, 1 length, 2 reload, 3 mode |
| cfg_addr | input | 8 | Table entry index for table writes |
| cfg_data | input | 16 | Write data |
| start_local | input | 1 | Local start request |
| start_host | input | 1 | Start request from host interface |
| abort | input | 1 | Stop playback and return to idle |
| dac_code | output | 12 | DAC output register |
| dac_oe | output | 1 | Output drive enable (load connected) |
| report_stb | output | 1 | One-cycle strobe per new sample |
| seq_state | output | 2 | Sequencer state code |

## Verification
The hardest case to reach from the ports is a write that arrives while the block is running. The write must be shown to have done nothing, yet the table cannot be read back. The stimulus overwrites entry 0 in the step just before the repeat wrap and checks that the old code still plays. It then aborts, re-arms and plays a single pass to confirm that the stored entry never changed. A full 256-entry repeat run covers the widest address wrap.

// File: rtl/wseq_pkg.sv
// Shared types for the waveform sequencer.
package wseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_TABLE = 2'd0,
        SEL_LEN   = 2'd1,
        SEL_DIV   = 2'd2,
        SEL_MODE  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/wseq_cfg.sv
// Parameter store: sample table, length, tick reload and mode flag.
// Assumes CFG_W is at least SAMPLE_W, DIV_W and the address width.
// Writes are accepted only while allow is high.
module wseq_cfg #(
    parameter int SAMPLE_W = 12,
    parameter int DEPTH    = 256,
    parameter int DIV_W    = 16,
    parameter int CFG_W    = 16,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [AW-1:0]       wr_addr,
    input  logic [CFG_W-1:0]    wr_data,
    input  logic                allow,
    input  logic [AW-1:0]       rd_addr,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic [AW-1:0]       len_m1,
    output logic [DIV_W-1:0]    divisor,
    output logic                periodic,
    output logic                wr_taken,
    output logic                mode_taken
);
    import wseq_pkg::*;

    logic [SAMPLE_W-1:0] mem [DEPTH];

    // Qualify writes with the state-based permission.
    always_comb begin
        wr_taken   = wr_en && allow;
        mode_taken = wr_taken && (wr_sel == SEL_MODE);
    end

    // Table storage write port.
    always_ff @(posedge clk) begin
        if (wr_taken && wr_sel == SEL_TABLE)
            mem[wr_addr] <= wr_data[SAMPLE_W-1:0];
    end

    // Combinational table read for the current play address.
    assign rd_data = mem[rd_addr];

    // Scalar parameter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_m1   <= '0;
            divisor  <= '0;
            periodic <= 1'b0;
        end else if (wr_taken) begin
            case (wr_sel)
                SEL_LEN:  len_m1   <= wr_data[AW-1:0];
                SEL_DIV:  divisor  <= wr_data[DIV_W-1:0];
                SEL_MODE: periodic <= wr_data[0];
                default:  ;
            endcase
        end
    end

    // R8: parameters stay frozen whenever writes are not permitted.
    a_r8_frozen_params: assert property (@(posedge clk) disable iff (!rst_n)
        !allow |=> ($stable(len_m1) && $stable(divisor) && $stable(periodic)));
endmodule

// File: rtl/wseq_tick.sv
// Step-rate generator: a down-counter reloaded from the divisor.
// Assumes the divisor is stable while run is high. step fires when the
// count is zero, so steps are divisor+1 cycles apart.
module wseq_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             step
);
    logic [DIV_W-1:0] cnt_q;

    // Step request when counting is enabled and the count is exhausted.
    assign step = run && (cnt_q == '0);

    // Countdown with reload; parked at zero when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (cnt_q == '0)
            cnt_q <= divisor;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    // R4: the count never exceeds the programmed reload during a run.
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= divisor));
endmodule

// File: rtl/wseq_ctrl.sv
// Sequencer control: state machine, play address and the DAC output stage.
// Assumes rd_data is the table entry at rd_addr in the same cycle.
module wseq_ctrl #(
    parameter int SAMPLE_W = 12,
    parameter int DEPTH    = 256,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_local,
    input  logic                start_host,
    input  logic                abort,
    input  logic                wr_taken,
    input  logic                mode_taken,
    input  logic                step,
    input  logic [AW-1:0]       len_m1,
    input  logic                periodic,
    input  logic [SAMPLE_W-1:0] rd_data,
    output logic [AW-1:0]       rd_addr,
    output logic [1:0]          state,
    output logic                allow,
    output logic                run,
    output logic [SAMPLE_W-1:0] dac_code,
    output logic                dac_oe,
    output logic                report_stb
);
    import wseq_pkg::*;

    seq_state_e state_q;
    logic [AW-1:0] addr_q;
    logic          fin_q;
    logic          start_any;

    // Merge the two start sources.
    assign start_any = start_local || start_host;

    // Decode permissions from the state.
    always_comb begin
        allow   = (state_q != ST_RUN);
        run     = (state_q == ST_RUN);
        rd_addr = addr_q;
        state   = state_q;
    end

    // State machine, address counter and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            fin_q      <= 1'b0;
            dac_code   <= '0;
            dac_oe     <= 1'b0;
            report_stb <= 1'b0;
        end else begin
            report_stb <= 1'b0;
            if (abort) begin
                state_q <= ST_IDLE;
                dac_oe  <= 1'b0;
                addr_q  <= '0;
                fin_q   <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (mode_taken) state_q <= ST_ARMED;
                    end
                    ST_ARMED: begin
                        if (start_any) begin
                            state_q <= ST_RUN;
                            addr_q  <= '0;
                            fin_q   <= 1'b0;
                        end
                    end
                    ST_RUN: begin
                        if (step) begin
                            if (fin_q) begin
                                state_q <= ST_DONE;
                                dac_oe  <= 1'b0;
                            end else begin
                                dac_code   <= rd_data;
                                report_stb <= 1'b1;
                                dac_oe     <= 1'b1;
                                if (addr_q == len_m1) begin
                                    addr_q <= '0;
                                    fin_q  <= !periodic;
                                end else begin
                                    addr_q <= addr_q + 1'b1;
                                end
                            end
                        end
                    end
                    ST_DONE: begin
                        if (mode_taken)    state_q <= ST_ARMED;
                        else if (wr_taken) state_q <= ST_IDLE;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R5: the DAC code only changes together with the report strobe.
    a_r5_change_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code != $past(dac_code)) |-> report_stb);

    // R3: a run can only be entered from the armed state.
    a_r3_run_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> ($past(state_q) == ST_ARMED));

    // R9: abort lands in idle with the drive released.
    a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == ST_IDLE && !dac_oe));

    // R7: the done state never drives the load.
    a_r7_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> !dac_oe);

    // R6: in repeat mode the address wraps to zero and the run continues.
    a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && step && !fin_q && addr_q == len_m1 && periodic && !abort)
        |=> (addr_q == '0 && state_q == ST_RUN));

    // R10: a strobe is always accompanied by an enabled drive.
    a_r10_strobe_driven: assert property (@(posedge clk) disable iff (!rst_n)
        report_stb |-> dac_oe);
endmodule

// File: rtl/wave_sequencer.sv
// Top of the table-driven waveform sequencer: ties the parameter store,
// the tick generator and the control together. Assumes a single clock.
module wave_sequencer #(
    parameter int SAMPLE_W = 12,
    parameter int DEPTH    = 256,
    parameter int DIV_W    = 16,
    localparam int AW      = $clog2(DEPTH),
    localparam int CFG_W   = (DIV_W > SAMPLE_W) ? DIV_W : SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [CFG_W-1:0]    cfg_data,
    input  logic                start_local,
    input  logic                start_host,
    input  logic                abort,
    output logic [SAMPLE_W-1:0] dac_code,
    output logic                dac_oe,
    output logic                report_stb,
    output logic [1:0]          seq_state
);
    logic [SAMPLE_W-1:0] rd_data;
    logic [AW-1:0]       rd_addr;
    logic [AW-1:0]       len_m1;
    logic [DIV_W-1:0]    divisor;
    logic                periodic;
    logic                wr_taken;
    logic                mode_taken;
    logic                allow;
    logic                run;
    logic                step;

    wseq_cfg #(
        .SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .DIV_W(DIV_W), .CFG_W(CFG_W)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_addr(cfg_addr), .wr_data(cfg_data),
        .allow(allow), .rd_addr(rd_addr), .rd_data(rd_data),
        .len_m1(len_m1), .divisor(divisor), .periodic(periodic),
        .wr_taken(wr_taken), .mode_taken(mode_taken)
    );

    wseq_tick #(.DIV_W(DIV_W)) i_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .divisor(divisor), .step(step)
    );

    wseq_ctrl #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_local(start_local), .start_host(start_host), .abort(abort),
        .wr_taken(wr_taken), .mode_taken(mode_taken), .step(step),
        .len_m1(len_m1), .periodic(periodic), .rd_data(rd_data),
        .rd_addr(rd_addr), .state(seq_state), .allow(allow), .run(run),
        .dac_code(dac_code), .dac_oe(dac_oe), .report_stb(report_stb)
    );
endmodule

// File: tb/test_wave_sequencer.sv
module test_wave_sequencer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic        start_local = 1'b0;
    logic        start_host = 1'b0;
    logic        abort = 1'b0;
    logic [11:0] dac_code;
    logic        dac_oe;
    logic        report_stb;
    logic [1:0]  seq_state;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int tbl_m [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_sequencer i_wave_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .start_local(start_local),
        .start_host(start_host), .abort(abort), .dac_code(dac_code),
        .dac_oe(dac_oe), .report_stb(report_stb), .seq_state(seq_state)
    );

    function automatic int exp_idx(int j, int len);
        return j % len;
    endfunction

    function automatic int gap_of(int j, int dv);
        return (j == 0) ? 1 : dv + 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int addr, input int data);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_addr = 8'(addr); cfg_data = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prog(input int len, input int dv, input bit per);
        for (int i = 0; i < len; i++) begin
            tbl_m[i] = int'($urandom & 32'hFFF);
            wr(0, i, tbl_m[i]);
        end
        wr(1, 0, len - 1);
        wr(2, 0, dv);
        wr(3, 0, int'(per));
    endtask

    task automatic do_start(input bit host);
        if (host) start_host = 1'b1; else start_local = 1'b1;
        @(negedge clk);
        start_host = 1'b0; start_local = 1'b0;
        chk("R3 running after start", int'(seq_state), 2);
    endtask

    task automatic play(input int len, input int dv, input bit per, input int nsteps, input bit poke);
        int last;
        last = 0;
        for (int j = 0; j < nsteps; j++) begin
            for (int c = 1; c <= gap_of(j, dv); c++) begin
                @(negedge clk);
                cfg_we = 1'b0;
                if (c < gap_of(j, dv)) begin
                    chk("R5 no strobe between steps", int'(report_stb), 0);
                    if (j > 0) chk("R10 drive held", int'(dac_oe), 1);
                end else begin
                    chk("R5 strobe at step", int'(report_stb), 1);
                    chk("R4 sample value", int'(dac_code), tbl_m[exp_idx(j, len)]);
                    chk("R10 drive on", int'(dac_oe), 1);
                    chk("R8 still running", int'(seq_state), 2);
                    last = tbl_m[exp_idx(j, len)];
                end
                if (poke && j == len - 1 && c == gap_of(j, dv)) begin
                    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_addr = 8'd0;
                    cfg_data = 16'((~tbl_m[0]) & 12'hFFF);
                end
            end
        end
        if (!per) begin
            for (int c = 1; c <= dv + 1; c++) begin
                @(negedge clk);
                chk("R7 no strobe after last", int'(report_stb), 0);
                if (c <= dv) chk("R7 last held driven", int'(dac_oe), 1);
            end
            chk("R7 done state", int'(seq_state), 3);
            chk("R7 drive released", int'(dac_oe), 0);
            chk("R7 last value held", int'(dac_code), last);
        end
    endtask

    task automatic do_abort();
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R9 idle after abort", int'(seq_state), 0);
        chk("R9 drive off after abort", int'(dac_oe), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        chk("R1 state", int'(seq_state), 0);
        chk("R1 dac_code", int'(dac_code), 0);
        chk("R1 dac_oe", int'(dac_oe), 0);
        chk("R1 report_stb", int'(report_stb), 0);

        // R3 start in idle is ignored
        start_local = 1'b1; @(negedge clk); start_local = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3 start ignored in idle", int'(seq_state), 0);
        chk("R3 no strobe in idle", int'(report_stb), 0);

        // R2 non-mode writes do not arm
        wr(0, 0, 12'h123); wr(1, 0, 0);
        chk("R2 idle after table write", int'(seq_state), 0);

        // R4 R7 single pass, local start, then start in done ignored
        prog(4, 3, 1'b0);
        chk("R2 armed after mode write", int'(seq_state), 1);
        do_start(1'b0);
        play(4, 3, 1'b0, 4, 1'b0);
        start_local = 1'b1; @(negedge clk); start_local = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 start ignored in done", int'(seq_state), 3);
        chk("R7 no strobe in done", int'(report_stb), 0);
        wr(2, 0, 1);
        chk("R2 done to idle on write", int'(seq_state), 0);

        // R6 R8 repeat mode, host start, write poked before wrap
        prog(3, 1, 1'b1);
        do_start(1'b1);
        play(3, 1, 1'b1, 10, 1'b1);
        do_abort();
        // R8 table entry 0 unchanged: re-arm and play once
        wr(3, 0, 0);
        do_start(1'b0);
        play(3, 1, 1'b0, 3, 1'b0);

        // R6 full-depth wrap
        prog(256, 0, 1'b1);
        do_start(1'b1);
        play(256, 0, 1'b1, 300, 1'b0);
        do_abort();

        // R4 long spacing gives a shallow slope
        prog(2, 500, 1'b0);
        do_start(1'b0);
        play(2, 500, 1'b0, 2, 1'b0);

        // R9 abort in armed beats a simultaneous start
        prog(2, 0, 1'b1);
        abort = 1'b1; start_host = 1'b1;
        @(negedge clk);
        abort = 1'b0; start_host = 1'b0;
        chk("R9 abort beats start", int'(seq_state), 0);
        start_host = 1'b1; @(negedge clk); start_host = 1'b0;
        chk("R3 start ignored after abort", int'(seq_state), 0);

        // Random mix of lengths, reloads, modes and start sources
        for (int k = 0; k < 20; k++) begin
            int len; int dv; bit per; bit host;
            len  = 1 + int'($urandom % 16);
            dv   = int'($urandom % 6);
            per  = 1'($urandom);
            host = 1'($urandom);
            prog(len, dv, per);
            do_start(host);
            play(len, dv, per, per ? 2 * len + 1 : len, 1'b0);
            if (per) do_abort();
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule